// File: doc/BRIEF.md
# DDR2 Power-Up Command Sequencer

This block takes a DDR2 memory device from reset to normal operation without software help. After a single start pulse it programs the PHY delay-locked loop with two control writes. It then waits for both PHY lock indications, lets the memory clock run for a 200 µs settling period, and steps through the fixed thirteen-command initialisation list. Each command is presented as a 32-bit word with a valid strobe and is held until the command path acknowledges it.

The CAS latency and write-recovery inputs are packed into the mode-register words. The first mode-register load also resets the device DLL. A second load, issued after the refresh pair, leaves that bit clear. Fixed waits of at least 1 µs follow the steps that need settling time. The waits are derived from a clock-frequency parameter and rounded up to whole cycles. If the PHY never locks within a parameterised bound, the block raises an error and stops. On success it raises a done flag. Both flags hold until reset.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, cmd_valid, dll_we, done and err are all low.
- R2: A start pulse in the idle state makes dll_we high for exactly two cycles. dll_word is 0x00022828 on the first of these cycles and 0x00032828 on the second. No command is issued while dll_we is high.
- R3: The sequence leaves the lock wait only on a clock edge where phy_lock equals 2'b11. A value with only one bit set does not count.
- R4: If phy_lock is not 2'b11 within LOCK_TIMEOUT clock edges after the second DLL write, err goes high and no command is ever issued. err then stays high until reset.
- R5: The first command appears exactly PWR_CYC cycles after the lock edge. PWR_CYC is 200 µs of clock, rounded up: 20000 cycles at 100 MHz.
- R6: Commands are issued in this order: wake-up 0x80FC0000, NOP 0x803C0000, precharge-all 0x80280400, EMR2 0x80220000, EMR3 0x80230000, EMR1, DLL-reset mode load, precharge-all, auto-refresh 0x80240000 twice, mode load, EMR1 with OCD default, EMR1.
- R7: The EMR1 word is 0x80210006, which selects 75-ohm ODT and reduced drive with the DLL enabled. The OCD-default step sends 0x80210386. The OCD-exit step sends 0x80210006.
- R8: The mode word is 0x80200003 + cas_lat×16 + (wr_rec−1)×512. The first mode load adds 0x100 to reset the DLL. The second mode load does not add it.
- R9: While cmd_valid is high and cmd_ack is low, cmd_valid and cmd_word stay unchanged. A command counts as accepted on a rising edge where cmd_valid and cmd_ack are both high. The next command word may appear on the cycle right after that edge.
- R10: After acceptance of the EMR1, DLL-reset mode, precharge-all, both auto-refresh and second mode commands, cmd_valid stays low for exactly US_CYC cycles before the next command. US_CYC is 1 µs of clock, rounded up.
- R11: done goes high on the cycle after the final EMR1 is accepted and stays high until reset. A start pulse received anywhere except the idle state has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, acted on only when idle |
| phy_lock | input | 2 | PHY lock status bits, both high when locked |
| cmd_ack | input | 1 | Command accepted and completed |
| cas_lat | input | 3 | CAS latency packed into the mode word |
| wr_rec | input | 3 | Write recovery in clocks, 2 to 7 |
| cmd_valid | output | 1 | Command word valid |
| cmd_word | output | 32 | Memory command word |
| dll_we | output | 1 | PHY DLL control write strobe |
| dll_word | output | 32 | PHY DLL control word |
| done | output | 1 | Initialisation complete, sticky |
| err | output | 1 | Lock timeout, sticky |

## Verification
A wrong step index shows up at the first acceptance after it goes wrong, as a command word out of order or as a pause where none belongs. A wrong count in the shared wait counter moves the next valid edge by one or more cycles, and the bench sees this on the cycle it happens. A lock decision that accepts a single set bit, or that times out one edge early or late, moves the whole command train or the err rise by at least one cycle. Because every output is compared against the reference on every clock, such faults appear within a cycle of the divergence.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  localparam int NUM_STEPS = 13;
  localparam int LAST_STEP = NUM_STEPS - 1;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  localparam logic [31:0] DLL_ON_WORD = 32'h0002_2828;
  localparam logic [31:0] DLL_GO_WORD = 32'h0003_2828;

  localparam logic [31:0] CMD_WAKE  = 32'h80FC_0000;
  localparam logic [31:0] CMD_NOP   = 32'h803C_0000;
  localparam logic [31:0] CMD_PALL  = 32'h8028_0400;
  localparam logic [31:0] CMD_EMR2  = 32'h8022_0000;
  localparam logic [31:0] CMD_EMR3  = 32'h8023_0000;
  localparam logic [31:0] CMD_AREF  = 32'h8024_0000;
  localparam logic [31:0] CMD_EMR1  = 32'h8021_0000 | 32'h4 | 32'h2;
  localparam logic [31:0] OCD_DFLT  = 32'h0000_0380;

  typedef enum logic [3:0] {
    S_IDLE, S_DLL_ON, S_DLL_GO, S_LOCK, S_PWR, S_ISSUE, S_GAP, S_DONE, S_FAIL
  } seq_state_t;

  function automatic logic [31:0] mode_word(input logic [2:0] cl,
                                            input logic [2:0] wr,
                                            input logic       dll_rst);
    return 32'h8020_0003 + (32'(cl) << 4) + (32'(wr - 3'd1) << 9)
           + (dll_rst ? 32'h100 : 32'h0);
  endfunction

  function automatic logic gap_after(input logic [STEP_W-1:0] s);
    return (s >= STEP_W'(5)) && (s <= STEP_W'(10));
  endfunction

endpackage

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // Wait windows of R5 and R10 depend on a strict one-per-cycle count.
  p_count_down_r10: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ddr2_cmd_table.sv
module ddr2_cmd_table
  import ddr2_init_pkg::*;
(
  input  logic [STEP_W-1:0] idx,
  input  logic [2:0]        cas_lat,
  input  logic [2:0]        wr_rec,
  output logic [31:0]       word
);
  always_comb begin
    case (idx)
      STEP_W'(0):  word = CMD_WAKE;
      STEP_W'(1):  word = CMD_NOP;
      STEP_W'(2):  word = CMD_PALL;
      STEP_W'(3):  word = CMD_EMR2;
      STEP_W'(4):  word = CMD_EMR3;
      STEP_W'(5):  word = CMD_EMR1;
      STEP_W'(6):  word = mode_word(cas_lat, wr_rec, 1'b1);
      STEP_W'(7):  word = CMD_PALL;
      STEP_W'(8):  word = CMD_AREF;
      STEP_W'(9):  word = CMD_AREF;
      STEP_W'(10): word = mode_word(cas_lat, wr_rec, 1'b0);
      STEP_W'(11): word = CMD_EMR1 + OCD_DFLT;
      STEP_W'(12): word = CMD_EMR1;
      default:     word = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int CLK_KHZ      = 100000,
  parameter int LOCK_TIMEOUT = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [1:0]  phy_lock,
  input  logic        cmd_ack,
  input  logic [2:0]  cas_lat,
  input  logic [2:0]  wr_rec,
  output logic        cmd_valid,
  output logic [31:0] cmd_word,
  output logic        dll_we,
  output logic [31:0] dll_word,
  output logic        done,
  output logic        err
);
  localparam int US_CYC  = (CLK_KHZ + 999) / 1000;
  localparam int PWR_CYC = (200 * CLK_KHZ + 999) / 1000;
  localparam int MAX_A   = (PWR_CYC > LOCK_TIMEOUT) ? PWR_CYC : LOCK_TIMEOUT;
  localparam int MAX_C   = (MAX_A > US_CYC) ? MAX_A : US_CYC;
  localparam int TW      = $clog2(MAX_C + 1);

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] tbl_idx;
  logic [31:0]       tbl_word;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  logic              lock_ok, accept;

  assign lock_ok = (phy_lock == 2'b11);
  assign accept  = cmd_valid && cmd_ack;
  assign tbl_idx = (state == S_ISSUE) ? step + 1'b1 : step;

  ddr2_cmd_table u_table (
    .idx(tbl_idx), .cas_lat(cas_lat), .wr_rec(wr_rec), .word(tbl_word)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      S_DLL_GO: begin tmr_load = 1'b1; tmr_val = TW'(LOCK_TIMEOUT - 1); end
      S_LOCK:   if (lock_ok) begin tmr_load = 1'b1; tmr_val = TW'(PWR_CYC - 1); end
      S_ISSUE:  if (accept && gap_after(step)) begin
                  tmr_load = 1'b1; tmr_val = TW'(US_CYC - 1);
                end
      default:  ;
    endcase
  end

  ddr2_wait_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      step      <= '0;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
      dll_we    <= 1'b0;
      dll_word  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          dll_we   <= 1'b1;
          dll_word <= DLL_ON_WORD;
          state    <= S_DLL_ON;
        end
        S_DLL_ON: begin
          dll_word <= DLL_GO_WORD;
          state    <= S_DLL_GO;
        end
        S_DLL_GO: begin
          dll_we <= 1'b0;
          state  <= S_LOCK;
        end
        S_LOCK: begin
          if (lock_ok)       state <= S_PWR;
          else if (tmr_zero) begin err <= 1'b1; state <= S_FAIL; end
        end
        S_PWR, S_GAP: if (tmr_zero) begin
          cmd_valid <= 1'b1;
          cmd_word  <= tbl_word;
          state     <= S_ISSUE;
        end
        S_ISSUE: if (accept) begin
          if (step == STEP_W'(LAST_STEP)) begin
            cmd_valid <= 1'b0;
            done      <= 1'b1;
            state     <= S_DONE;
          end else if (gap_after(step)) begin
            cmd_valid <= 1'b0;
            step      <= step + 1'b1;
            state     <= S_GAP;
          end else begin
            cmd_word  <= tbl_word;
            step      <= step + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_word)));
  p_lock_needed_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOCK && !lock_ok && !tmr_zero) |=> (state == S_LOCK));
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    err |=> (err && !cmd_valid));
  p_done_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !cmd_valid));
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> (state != S_IDLE));
  p_dll_first_r2: assert property (@(posedge clk) disable iff (rst)
    dll_we |-> (!cmd_valid && !done && !err));
  p_gap_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (state == S_GAP) |-> !cmd_valid);

endmodule

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;
  localparam int CLK_KHZ = 100000;
  localparam int LT      = 4096;
  localparam int US      = (CLK_KHZ + 999) / 1000;
  localparam int PWR     = (200 * CLK_KHZ + 999) / 1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  phy_lock = 2'b00;
  logic        cmd_ack = 1'b0;
  logic [2:0]  cas_lat = 3'd6;
  logic [2:0]  wr_rec = 3'd6;
  logic        cmd_valid, dll_we, done, err;
  logic [31:0] cmd_word, dll_word;

  int checks = 0, errors = 0;
  int ack_dly = 0, acnt = 0;
  bit checking = 0;

  logic        exp_valid = 0, exp_dll_we = 0, exp_done = 0, exp_err = 0;
  logic [31:0] exp_word = 0, exp_dll_word = 0;
  string       tag = "R1";
  int          m_step = 0;
  bit          m_busy = 0;

  ddr2_init_seq #(.CLK_KHZ(CLK_KHZ), .LOCK_TIMEOUT(LT)) dut (
    .clk(clk), .rst(rst), .start(start), .phy_lock(phy_lock), .cmd_ack(cmd_ack),
    .cas_lat(cas_lat), .wr_rec(wr_rec), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .dll_we(dll_we), .dll_word(dll_word), .done(done), .err(err)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mword(input int cl, input int wr, input bit r);
    return 32'h80200003 + cl * 16 + (wr - 1) * 512 + (r ? 256 : 0);
  endfunction

  function automatic string wtag(input int s);
    if (s == 5 || s == 11 || s == 12) return "R7";
    if (s == 6 || s == 10) return "R8";
    return "R6";
  endfunction

  task automatic run_seq();
    logic [31:0] w [13];
    bit locked = 0;
    w[0] = 32'h80FC0000; w[1] = 32'h803C0000; w[2] = 32'h80280400;
    w[3] = 32'h80220000; w[4] = 32'h80230000; w[5] = 32'h80210006;
    w[6] = mword(int'(cas_lat), int'(wr_rec), 1'b1);
    w[7] = 32'h80280400; w[8] = 32'h80240000; w[9] = 32'h80240000;
    w[10] = mword(int'(cas_lat), int'(wr_rec), 1'b0);
    w[11] = 32'h80210386; w[12] = 32'h80210006;
    tag = "R2";
    exp_dll_we = 1; exp_dll_word = 32'h00022828;
    @(posedge clk); exp_dll_word = 32'h00032828;
    @(posedge clk); exp_dll_we = 0; tag = "R3";
    for (int k = 0; k < LT; k++) begin
      @(posedge clk);
      if (phy_lock == 2'b11) begin locked = 1; break; end
    end
    if (!locked) begin exp_err = 1; tag = "R4"; return; end
    tag = "R5";
    repeat (PWR) @(posedge clk);
    for (int s = 0; s < 13; s++) begin
      exp_valid = 1; exp_word = w[s]; m_step = s; tag = "R9";
      do @(posedge clk); while (!cmd_ack);
      if (s == 12) begin
        exp_valid = 0; exp_done = 1; tag = "R11";
      end else if (s >= 5 && s <= 10) begin
        exp_valid = 0; tag = "R10";
        repeat (US) @(posedge clk);
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rst) begin
        exp_valid = 0; exp_dll_we = 0; exp_done = 0; exp_err = 0;
        m_busy = 0; tag = "R1";
      end else if (!m_busy && start) begin
        m_busy = 1;
        run_seq();
      end
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      cmd_ack = 0; acnt = 0;
    end else if (cmd_valid && !cmd_ack && acnt >= ack_dly) begin
      cmd_ack = 1; acnt = 0;
    end else begin
      if (cmd_valid && !cmd_ack) acnt++;
      cmd_ack = 0;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      chk(cmd_valid == exp_valid, tag, 32'(cmd_valid), 32'(exp_valid));
      if (exp_valid) chk(cmd_word == exp_word, wtag(m_step), cmd_word, exp_word);
      chk(dll_we == exp_dll_we, "R2", 32'(dll_we), 32'(exp_dll_we));
      if (exp_dll_we) chk(dll_word == exp_dll_word, "R2", dll_word, exp_dll_word);
      chk(done == exp_done, "R11", 32'(done), 32'(exp_done));
      chk(err == exp_err, "R4", 32'(err), 32'(exp_err));
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1; phy_lock = 2'b00; start = 0;
    repeat (3) @(negedge clk);
    checking = 1;
    rst = 0;
    @(negedge clk);
    chk(!cmd_valid && !dll_we && !done && !err, "R1",
        {28'd0, cmd_valid, dll_we, done, err}, 32'd0);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 30000 && !done; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Run 1: CL6, WR6, immediate ack, partial lock first (R3)
    cas_lat = 3'd6; wr_rec = 3'd6; ack_dly = 0;
    do_reset();
    pulse_start();
    phy_lock = 2'b10;
    repeat (8) @(negedge clk);
    chk(!cmd_valid, "R3", 32'(cmd_valid), 32'd0);
    phy_lock = 2'b11;
    repeat (100) @(negedge clk);
    pulse_start();                      // R11: ignored while running
    wait_done();
    chk(done, "R11", 32'(done), 32'd1);
    repeat (5) @(negedge clk);
    pulse_start();                      // R11: ignored after done
    repeat (10) @(negedge clk);
    chk(done && !dll_we && !cmd_valid, "R11", {30'd0, done, cmd_valid}, 32'd2);

    // Run 2: CL5, WR3, slow ack, single low bit lock first
    cas_lat = 3'd5; wr_rec = 3'd3; ack_dly = 3;
    do_reset();
    pulse_start();
    phy_lock = 2'b01;
    repeat (20) @(negedge clk);
    phy_lock = 2'b11;
    wait_done();
    chk(done, "R8", 32'(done), 32'd1);

    // Run 3: lock never arrives (R4)
    ack_dly = 0;
    do_reset();
    pulse_start();
    phy_lock = 2'b10;
    repeat (LT + 20) @(negedge clk);
    chk(err && !cmd_valid, "R4", {30'd0, err, cmd_valid}, 32'd2);
    pulse_start();
    repeat (10) @(negedge clk);
    chk(err && !dll_we && !cmd_valid, "R4", {29'd0, err, dll_we, cmd_valid}, 32'd4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule